// File: doc/BRIEF.md
# Two-Wire Unlocked Register Programming Port

This block takes frequency words over a two-wire link whose pins double as clock-select inputs. The host drives a link clock wire and a link data wire. Both wires are oversampled by a faster system clock. The block first waits for an unlock preamble. It then decodes bits that each arrive as a pair of samples: the inverse of the bit on the falling edge of the link clock, then the bit itself on the rising edge. A framed 24-bit word ends in a stop symbol, and on that symbol the block writes 21 data bits to the register named by a 3-bit address.

A quiet-line watchdog counts system clock cycles and restarts on every change of either wire. When it runs out, it abandons any transfer in progress. While it is still counting, a programming-active flag tells the clock-select logic to leave the shared wires alone. Every completed transfer produces exactly one of two single-cycle pulses: a write strobe or an error pulse.

Top module: `prog_link_port`

## Requirements
- R1: After reset, `wr_stb`, `err_pulse` and `prog_active` are all low.
- R2: Unlocking takes five or more consecutive link-clock rising edges sampled with data high, followed directly by one rising edge with data low. With only four high-data rising edges the link stays locked, and a later frame writes nothing.
- R3: A bit is valid only when the data level at the falling edge differs from the level at the next rising edge, and its value is the rising-edge level. If both levels are low, the block raises one error pulse and drops back to locked.
- R4: After unlock, a start bit of value 0 is followed by 24 bits sent most significant first, then a stop symbol. The first 21 bits form `wr_data`, with bit 20 sent first. The last 3 bits form `wr_addr`. The stop symbol is data high on both the falling edge and the rising edge, and it produces one `wr_stb` pulse.
- R5: A stop symbol that arrives before all 24 bits are in produces one error pulse and no write.
- R6: A 25th valid bit produces one error pulse and no write.
- R7: Addresses 3'b101 and 3'b111 are undefined. A complete frame that names one of them produces an error pulse and no write strobe.
- R8: If no wire changes for `WD_CYCLES` system cycles, the link returns to locked and any partial word is discarded. Bits sent after that write nothing until a new preamble.
- R9: While `pwr_down` is high, no frame is accepted and neither pulse is produced.
- R10: `prog_active` rises after any wire change and falls about `WD_CYCLES` cycles after the last change.
- R11: After a write the link is locked again, so a following frame without a preamble writes nothing.
- R12: `wr_stb` and `err_pulse` are never high in the same cycle, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the link clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_clk | input | 1 | Link clock wire (shared with select bit 0) |
| link_dat | input | 1 | Link data wire (shared with select bit 1) |
| pwr_down | input | 1 | High while the device is powered down |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 3 | Register address of the write |
| wr_data | output | 21 | Data of the write: index, N, mux, M |
| err_pulse | output | 1 | One-cycle framing error indication |
| prog_active | output | 1 | Wires are busy; select logic must ignore them |

## Verification
A wrong internal state shows up at the ports at the end of the frame. A miscounted preamble or bit counter gives a missing or extra `wr_stb`, or an `err_pulse` where none is due, within a few system cycles of the stop symbol or of the 25th bit. A bad shift order shows as wrong `wr_data` or `wr_addr` at the strobe. A watchdog that fails to reset the decoder appears as a write from a frame that should have been dropped. A wrong watchdog count moves the falling edge of `prog_active` away from its expected window.

// File: rtl/prog_link_pkg.sv
package prog_link_pkg;
  localparam int DATA_W  = 21;
  localparam int ADDR_W  = 3;
  localparam int WORD_W  = DATA_W + ADDR_W;
  localparam int PIN_CLK = 0;
  localparam int PIN_DAT = 1;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SHIFT = 2'd2
  } link_st_t;

  typedef struct packed {
    logic [3:0] idx;
    logic [6:0] nval;
    logic [2:0] mux;
    logic [6:0] mval;
  } freq_word_t;

  function automatic logic addr_defined(input logic [ADDR_W-1:0] a);
    return (a != 3'b101) && (a != 3'b111);
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] chg
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= pin_in[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign lvl[i] = s2_q;
    assign chg[i] = s2_q ^ s3_q;
  end
endmodule

// File: rtl/quiet_watchdog.sv
module quiet_watchdog #(
  parameter int WD_CYCLES = 400000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_chg,
  output logic fire,
  output logic active
);
  localparam int CW = $clog2(WD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (any_chg)
      cnt_n = '0;
    else if (cnt_q != LIMIT)
      cnt_n = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LIMIT;
    else        cnt_q <= cnt_n;
  end

  assign fire   = !any_chg && (cnt_q == LIMIT - CW'(1));
  assign active = (cnt_q != LIMIT);

  a_r10_change_arms: assert property (@(posedge clk) disable iff (!rst_n)
    any_chg |=> active);
  a_r10_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !active);
endmodule

// File: rtl/link_decoder.sv
module link_decoder
  import prog_link_pkg::*;
#(
  parameter int PRE_MIN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pin_lvl,
  input  logic              clk_chg,
  input  logic              pwr_down,
  input  logic              wd_fire,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output freq_word_t        wr_data,
  output logic              err_pulse
);
  localparam int OW = $clog2(PRE_MIN + 1);
  localparam int BW = $clog2(WORD_W + 1);
  localparam logic [OW-1:0] ONES_MAX = OW'(PRE_MIN);
  localparam logic [BW-1:0] FULL     = BW'(WORD_W);

  link_st_t          st_q, st_n;
  logic [OW-1:0]     ones_q, ones_n;
  logic [BW-1:0]     cnt_q, cnt_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic              fall_q, fall_n;
  logic              stb_q, stb_n, err_q, err_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  freq_word_t        data_q, data_n;

  logic dat, rise, fall, pair_bit, pair_stop;
  assign dat       = pin_lvl[PIN_DAT];
  assign rise      = clk_chg & pin_lvl[PIN_CLK];
  assign fall      = clk_chg & ~pin_lvl[PIN_CLK];
  assign pair_bit  = fall_q != dat;
  assign pair_stop = fall_q & dat;

  always_comb begin
    st_n   = st_q;
    ones_n = ones_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    fall_n = fall_q;
    stb_n  = 1'b0;
    err_n  = 1'b0;
    addr_n = addr_q;
    data_n = data_q;
    if (pwr_down || wd_fire) begin
      st_n   = ST_HUNT;
      ones_n = '0;
    end else begin
      case (st_q)
        ST_HUNT: begin
          if (rise) begin
            if (dat) begin
              if (ones_q != ONES_MAX) ones_n = ones_q + OW'(1);
            end else begin
              if (ones_q == ONES_MAX) st_n = ST_ARMED;
              ones_n = '0;
            end
          end
        end
        ST_ARMED: begin
          if (fall) fall_n = dat;
          if (rise) begin
            if (pair_bit && !dat) begin
              st_n  = ST_SHIFT;
              cnt_n = '0;
            end else begin
              err_n = 1'b1;
              st_n  = ST_HUNT;
            end
          end
        end
        ST_SHIFT: begin
          if (fall) fall_n = dat;
          if (rise) begin
            if (pair_bit) begin
              if (cnt_q == FULL) begin
                err_n = 1'b1;
                st_n  = ST_HUNT;
              end else begin
                sh_n  = {sh_q[WORD_W-2:0], dat};
                cnt_n = cnt_q + BW'(1);
              end
            end else if (pair_stop) begin
              st_n = ST_HUNT;
              if (cnt_q == FULL && addr_defined(sh_q[ADDR_W-1:0])) begin
                stb_n  = 1'b1;
                addr_n = sh_q[ADDR_W-1:0];
                data_n = freq_word_t'(sh_q[WORD_W-1:ADDR_W]);
              end else begin
                err_n = 1'b1;
              end
            end else begin
              err_n = 1'b1;
              st_n  = ST_HUNT;
            end
          end
        end
        default: st_n = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      ones_q <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      fall_q <= 1'b0;
      stb_q  <= 1'b0;
      err_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      st_q   <= st_n;
      ones_q <= ones_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      fall_q <= fall_n;
      stb_q  <= stb_n;
      err_q  <= err_n;
      addr_q <= addr_n;
      data_q <= data_n;
    end
  end

  assign wr_stb    = stb_q;
  assign err_pulse = err_q;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && err_pulse));
  a_r12_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  a_r12_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);
  a_r7_defined_addr: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> addr_defined(wr_addr));
  a_r9_pd_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !wr_stb && !err_pulse);
  a_r8_wd_locks: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> st_q == ST_HUNT);
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_SHIFT |-> cnt_q <= FULL);
endmodule

// File: rtl/prog_link_port.sv
module prog_link_port
  import prog_link_pkg::*;
#(
  parameter int PRE_MIN   = 5,
  parameter int WD_CYCLES = 400000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_clk,
  input  logic        link_dat,
  input  logic        pwr_down,
  output logic        wr_stb,
  output logic [2:0]  wr_addr,
  output logic [20:0] wr_data,
  output logic        err_pulse,
  output logic        prog_active
);
  logic [1:0] pin_lvl, pin_chg;
  logic       wd_fire;
  freq_word_t word;

  pin_sync #(.W(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in ({link_dat, link_clk}),
    .lvl    (pin_lvl),
    .chg    (pin_chg)
  );

  quiet_watchdog #(.WD_CYCLES(WD_CYCLES)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_chg (|pin_chg),
    .fire    (wd_fire),
    .active  (prog_active)
  );

  link_decoder #(.PRE_MIN(PRE_MIN)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_lvl   (pin_lvl),
    .clk_chg   (pin_chg[PIN_CLK]),
    .pwr_down  (pwr_down),
    .wd_fire   (wd_fire),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (word),
    .err_pulse (err_pulse)
  );

  assign wr_data = word;
endmodule

// File: tb/tb_prog_link_port.sv
`timescale 1ns/1ps
module tb_prog_link_port;
  localparam int WD = 64;
  localparam int HP = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic link_clk = 1'b0, link_dat = 1'b0, pwr_down = 1'b0;
  logic wr_stb, err_pulse, prog_active;
  logic [2:0]  wr_addr;
  logic [20:0] wr_data;

  int checks = 0, errors = 0;
  int n_stb = 0, n_err = 0;
  logic [2:0]  cap_addr;
  logic [20:0] cap_data;

  always #2.5 clk = ~clk;

  prog_link_port #(.PRE_MIN(5), .WD_CYCLES(WD)) dut (
    .clk(clk), .rst_n(rst_n), .link_clk(link_clk), .link_dat(link_dat),
    .pwr_down(pwr_down), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .err_pulse(err_pulse), .prog_active(prog_active)
  );

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      n_stb++;
      cap_addr = wr_addr;
      cap_data = wr_data;
    end
    if (rst_n && err_pulse) n_err++;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic preamble(input int n_ones);
    for (int i = 0; i < n_ones; i++) begin
      link_dat = 1'b1; hold(HP);
      link_clk = 1'b1; hold(HP);
      link_clk = 1'b0; hold(HP);
    end
    link_dat = 1'b0; hold(HP);
    link_clk = 1'b1; hold(HP);
  endtask

  task automatic send_bit(input logic b);
    link_dat = ~b;   hold(HP);
    link_clk = 1'b0; hold(HP);
    link_dat = b;    hold(HP);
    link_clk = 1'b1; hold(HP);
  endtask

  task automatic send_stop();
    link_dat = 1'b1; hold(HP);
    link_clk = 1'b0; hold(HP);
    link_clk = 1'b1; hold(HP);
  endtask

  task automatic send_bits(input logic [23:0] w, input int n);
    for (int i = 23; i > 23 - n; i--) send_bit(w[i]);
  endtask

  task automatic settle();
    link_clk = 1'b0; link_dat = 1'b0;
    hold(WD + 20);
  endtask

  task automatic clear();
    n_stb = 0; n_err = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 stb", wr_stb, 0);
    check("R1 err", err_pulse, 0);
    check("R1 active", prog_active, 0);
  endtask

  task automatic t_good(input int ones, input logic [20:0] d, input logic [2:0] a);
    clear();
    preamble(ones);
    send_bit(1'b0);
    send_bits({d, a}, 24);
    send_stop();
    check("R4 active during", prog_active, 1);
    settle();
    check("R4 stb count", n_stb, 1);
    check("R4 err count", n_err, 0);
    check("R4 data", cap_data, d);
    check("R4 addr", cap_addr, a);
  endtask

  task automatic t_short_preamble();
    clear();
    preamble(4);
    send_bit(1'b0);
    send_bits(24'h0, 24);
    send_stop();
    settle();
    check("R2 no write", n_stb, 0);
    check("R2 no err", n_err, 0);
  endtask

  task automatic t_bad_pair();
    clear();
    preamble(5);
    send_bit(1'b0);
    send_bits(24'h500000, 3);
    link_dat = 1'b0; hold(HP);
    link_clk = 1'b0; hold(HP);
    link_clk = 1'b1; hold(HP);
    settle();
    check("R3 err", n_err, 1);
    check("R3 no write", n_stb, 0);
  endtask

  task automatic t_short_frame();
    clear();
    preamble(5);
    send_bit(1'b0);
    send_bits(24'h123456, 10);
    send_stop();
    settle();
    check("R5 err", n_err, 1);
    check("R5 no write", n_stb, 0);
  endtask

  task automatic t_overflow();
    clear();
    preamble(5);
    send_bit(1'b0);
    send_bits(24'h000003, 24);
    send_bit(1'b0);
    send_stop();
    settle();
    check("R6 err", n_err, 1);
    check("R6 no write", n_stb, 0);
  endtask

  task automatic t_undef_addr(input logic [2:0] a);
    clear();
    preamble(5);
    send_bit(1'b0);
    send_bits({21'h0ABCDE, a}, 24);
    send_stop();
    settle();
    check("R7 err", n_err, 1);
    check("R7 no write", n_stb, 0);
  endtask

  task automatic t_watchdog();
    clear();
    preamble(5);
    send_bit(1'b0);
    send_bits(24'h000000, 10);
    hold(WD + 20);
    check("R10 quiet drops active", prog_active, 0);
    send_bits(24'h000000, 14);
    send_stop();
    settle();
    check("R8 no write", n_stb, 0);
    check("R8 no err", n_err, 0);
  endtask

  task automatic t_rearm();
    clear();
    preamble(5);
    send_bit(1'b0);
    send_bits({21'h155555, 3'b010}, 24);
    send_stop();
    send_bit(1'b0);
    send_bits(24'h000000, 24);
    send_stop();
    settle();
    check("R11 single write", n_stb, 1);
    check("R11 no err", n_err, 0);
  endtask

  task automatic t_powerdown();
    clear();
    pwr_down = 1'b1;
    hold(4);
    preamble(6);
    send_bit(1'b0);
    send_bits({21'h1FFFFF, 3'b001}, 24);
    send_stop();
    settle();
    pwr_down = 1'b0;
    hold(4);
    check("R9 no write", n_stb, 0);
    check("R9 no err", n_err, 0);
  endtask

  task automatic t_active_window();
    link_dat = 1'b1;
    hold(WD - 10);
    check("R10 still active", prog_active, 1);
    hold(20);
    check("R10 released", prog_active, 0);
    link_dat = 1'b0;
    hold(WD + 20);
  endtask

  initial begin
    hold(5);
    rst_n = 1'b1;
    hold(3);
    t_reset();
    t_good(5, 21'h1A5C3F, 3'b011);
    t_good(7, 21'h0F0F0E, 3'b110);
    t_good(5, 21'h000001, 3'b000);
    t_short_preamble();
    t_bad_pair();
    t_short_frame();
    t_overflow();
    t_undef_addr(3'b101);
    t_undef_addr(3'b111);
    t_watchdog();
    t_rearm();
    t_powerdown();
    t_active_window();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule